// File: doc/BRIEF.md
# Line Timing and Sandcastle Encoder

This block runs from a 500 kHz timebase and splits it into television lines of 32 clocks each, which gives roughly 15.6 kHz. On every line it produces a set of pulses with fixed widths, all counted in clock cycles. These are a line-start strobe, a line drive pulse of constant length and a one-clock gate for sampling the horizontal sync. It also produces a 2-bit code that merges three sources in priority order: the burst key, the line flyback and frame blanking. The analog stage after the block converts this code into a three-level sandcastle voltage.

A phase loop outside the block can ask for one clock of advance or retard. The request changes the length of the next line only, and at most one correction is applied to any one line. The block also drives a fast-loop select output for the frequency loop. This output is high while the loop is capturing after reset, and it stays high whenever VCR mode is asserted.

All outputs are registered. The line counter's next value is decoded into the pulse outputs, so each output changes on the edge where the count enters the position it belongs to.

Top module: `line_timing_top`

## Requirements
- R1: The line-start strobe is high for exactly one clock, at count 0 of every line. An uncorrected line lasts 32 clocks from one strobe to the next.
- R2: The line drive output is high for 13 consecutive clocks, at counts 0 to 12 of every line.
- R3: The sync sampling gate is high for one clock only, at count 1 of every line.
- R4: The sandcastle code is 3 (burst) at counts 3 and 4. It is 2 (flyback) at the other counts where line drive is high. Outside drive it is 1 when frame blanking is active and 0 otherwise, so burst has priority over flyback and flyback has priority over blanking.
- R5: An advance request (advance input high, retard input low) made during a line shortens the following line to 31 clocks. The line after that is 32 clocks again.
- R6: A retard request (retard input high, advance input low) made during a line lengthens the following line to 33 clocks. The line after that is 32 clocks again.
- R7: Only one correction is held for each line. A second request that arrives while one is pending is dropped. A cycle with advance and retard both high is not a request.
- R8: The drive width and the gate position do not change on corrected lines.
- R9: While VCR mode is high, the fast-loop select output is high. It follows the mode input with one clock of latency.
- R10: After reset, the fast-loop select output stays high for the first 8 line ends. After that it follows the VCR mode input.
- R11: During reset, strobe, drive, gate and code are all 0 and fast-loop select is 1. Count 0 of the first line appears on the first clock edge after reset is released.
- R12: The frame blanking input reaches the code one clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 500 kHz timebase |
| rst_i | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Request to shorten the next line by one clock |
| ret_i | input | 1 | Request to lengthen the next line by one clock |
| blank_i | input | 1 | Frame blanking active |
| vcr_i | input | 1 | VCR mode: keeps the frequency loop fast |
| drive_o | output | 1 | Line drive pulse |
| gate_o | output | 1 | Sync sampling gate |
| sc_code_o | output | 2 | Sandcastle level code: 0 idle, 1 blank, 2 flyback, 3 burst |
| line_start_o | output | 1 | One-clock strobe at count 0 |
| fast_loop_o | output | 1 | Short time constant select for the frequency loop |

## Verification
The assertions rely on a phase loop that asks for a correction at most once per line. This keeps every strobe-to-strobe gap between 31 and 33 clocks. They also rely on the mode and blanking inputs changing only between edges. The directed tasks raise each request for a single clock just after a strobe, so the line being measured has a known length. The tasks change blanking and VCR mode on falling edges. They also exercise the two ways a request is refused, a second request in the same line and both directions at once, and confirm at the strobe spacing that neither of them alters a line.

// File: rtl/line_timing_pkg.sv
package line_timing_pkg;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ADV  = 2'd1,
        PH_RET  = 2'd2
    } phase_req_e;

    localparam logic [1:0] SC_IDLE  = 2'd0;
    localparam logic [1:0] SC_BLANK = 2'd1;
    localparam logic [1:0] SC_FLY   = 2'd2;
    localparam logic [1:0] SC_BURST = 2'd3;

    typedef struct packed {
        logic       start;
        logic       drive;
        logic       gate;
        logic [1:0] code;
    } pulse_t;

endpackage

// File: rtl/lt_line_counter.sv
module lt_line_counter
    import line_timing_pkg::*;
#(
    parameter int LINE_LEN = 32,
    localparam int CW = $clog2(LINE_LEN + 2)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          adv_i,
    input  logic          ret_i,
    output logic [CW-1:0] cnt_next_o,
    output logic          line_end_o
);
    localparam logic [CW-1:0] LAST = CW'(LINE_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] term;
        phase_req_e    pend;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    phase_req_e req, eff;
    logic       at_end;

    always_comb begin
        st_d = st_q;
        req  = PH_NONE;
        eff  = PH_NONE;
        if (adv_i && !ret_i) begin
            req = PH_ADV;
        end else if (ret_i && !adv_i) begin
            req = PH_RET;
        end
        at_end = (st_q.cnt == st_q.term);
        if (at_end) begin
            st_d.cnt = '0;
            eff = (st_q.pend != PH_NONE) ? st_q.pend : req;
            case (eff)
                PH_ADV:  st_d.term = LAST - CW'(1);
                PH_RET:  st_d.term = LAST + CW'(1);
                default: st_d.term = LAST;
            endcase
            st_d.pend = PH_NONE;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_q.pend == PH_NONE) begin
                st_d.pend = req;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt  <= LAST;
            st_q.term <= LAST;
            st_q.pend <= PH_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_next_o = st_d.cnt;
    assign line_end_o = at_end;

endmodule

// File: rtl/lt_pulse_decode.sv
module lt_pulse_decode
    import line_timing_pkg::*;
#(
    parameter int CW        = 6,
    parameter int DRIVE_LEN = 13,
    parameter int GATE_POS  = 1,
    parameter int BURST_LO  = 3,
    parameter int BURST_HI  = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [CW-1:0] cnt_next_i,
    input  logic          blank_i,
    output pulse_t        pulse_o
);
    pulse_t pls_d, pls_q;
    logic   in_burst;

    always_comb begin
        pls_d       = '0;
        pls_d.start = (cnt_next_i == '0);
        pls_d.drive = (cnt_next_i < CW'(DRIVE_LEN));
        pls_d.gate  = (cnt_next_i == CW'(GATE_POS));
        in_burst    = (cnt_next_i >= CW'(BURST_LO)) && (cnt_next_i <= CW'(BURST_HI));
        if (in_burst) begin
            pls_d.code = SC_BURST;
        end else if (pls_d.drive) begin
            pls_d.code = SC_FLY;
        end else if (blank_i) begin
            pls_d.code = SC_BLANK;
        end else begin
            pls_d.code = SC_IDLE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pls_q <= '0;
        end else begin
            pls_q <= pls_d;
        end
    end

    assign pulse_o = pls_q;

endmodule

// File: rtl/lt_loop_select.sv
module lt_loop_select #(
    parameter int CAPTURE_LINES = 8,
    localparam int KW = $clog2(CAPTURE_LINES + 1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_end_i,
    input  logic vcr_i,
    output logic fast_o
);
    typedef struct packed {
        logic [KW-1:0] cap;
        logic          fast;
    } sel_state_t;

    sel_state_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (line_end_i && (sel_q.cap < KW'(CAPTURE_LINES))) begin
            sel_d.cap = sel_q.cap + KW'(1);
        end
        sel_d.fast = vcr_i || (sel_d.cap < KW'(CAPTURE_LINES));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q.cap  <= '0;
            sel_q.fast <= 1'b1;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign fast_o = sel_q.fast;

endmodule

// File: rtl/line_timing_top.sv
module line_timing_top
    import line_timing_pkg::*;
#(
    parameter int LINE_LEN      = 32,
    parameter int DRIVE_LEN     = 13,
    parameter int GATE_POS      = 1,
    parameter int BURST_LO      = 3,
    parameter int BURST_HI      = 4,
    parameter int CAPTURE_LINES = 8
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       adv_i,
    input  logic       ret_i,
    input  logic       blank_i,
    input  logic       vcr_i,
    output logic       drive_o,
    output logic       gate_o,
    output logic [1:0] sc_code_o,
    output logic       line_start_o,
    output logic       fast_loop_o
);
    localparam int CW = $clog2(LINE_LEN + 2);

    logic [CW-1:0] cnt_next;
    logic          line_end;
    pulse_t        pulse;

    lt_line_counter #(.LINE_LEN(LINE_LEN)) u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .adv_i      (adv_i),
        .ret_i      (ret_i),
        .cnt_next_o (cnt_next),
        .line_end_o (line_end)
    );

    lt_pulse_decode #(
        .CW        (CW),
        .DRIVE_LEN (DRIVE_LEN),
        .GATE_POS  (GATE_POS),
        .BURST_LO  (BURST_LO),
        .BURST_HI  (BURST_HI)
    ) u_dec (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cnt_next_i (cnt_next),
        .blank_i    (blank_i),
        .pulse_o    (pulse)
    );

    lt_loop_select #(.CAPTURE_LINES(CAPTURE_LINES)) u_sel (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .line_end_i (line_end),
        .vcr_i      (vcr_i),
        .fast_o     (fast_loop_o)
    );

    assign drive_o      = pulse.drive;
    assign gate_o       = pulse.gate;
    assign sc_code_o    = pulse.code;
    assign line_start_o = pulse.start;

endmodule

// File: rtl/lt_checker.sv
module lt_checker #(
    parameter int LINE_LEN  = 32,
    parameter int DRIVE_LEN = 13,
    localparam int GW = $clog2(LINE_LEN + 4)
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       vcr_i,
    input logic       drive_o,
    input logic       gate_o,
    input logic [1:0] sc_code_o,
    input logic       line_start_o,
    input logic       fast_loop_o
);
    logic [GW-1:0] gap_q;
    logic [GW-1:0] run_q;
    logic          seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q  <= '0;
            run_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (line_start_o) begin
                gap_q  <= GW'(1);
                seen_q <= 1'b1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + GW'(1);
            end
            run_q <= drive_o ? run_q + GW'(1) : '0;
        end
    end

    // R1
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        line_start_o |=> !line_start_o);

    // R5 R6 R7
    period_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (line_start_o && seen_q) |-> (gap_q >= GW'(LINE_LEN - 1) && gap_q <= GW'(LINE_LEN + 1)));

    // R2
    drive_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(drive_o) |-> line_start_o);

    // R2 R8
    drive_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(drive_o) |-> (run_q == GW'(DRIVE_LEN)));

    // R3
    gate_after_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_o |-> $past(line_start_o));

    // R4
    burst_in_drive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sc_code_o == 2'd3) |-> drive_o);

    // R4
    flyback_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        drive_o |-> sc_code_o[1]);

    // R9
    vcr_fast_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(vcr_i) |-> fast_loop_o);

endmodule

bind line_timing_top lt_checker #(.LINE_LEN(LINE_LEN), .DRIVE_LEN(DRIVE_LEN)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .vcr_i        (vcr_i),
    .drive_o      (drive_o),
    .gate_o       (gate_o),
    .sc_code_o    (sc_code_o),
    .line_start_o (line_start_o),
    .fast_loop_o  (fast_loop_o)
);

// File: tb/tb_line_timing_top.sv
module tb_line_timing_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv = 1'b0, ret = 1'b0, blank = 1'b0, vcr = 1'b0;
    logic       drive, gate, strobe, fast;
    logic [1:0] code;

    int errors = 0;
    int checks = 0;
    logic [1:0] codes [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_timing_top dut (
        .clk_i(clk), .rst_i(rst), .adv_i(adv), .ret_i(ret), .blank_i(blank), .vcr_i(vcr),
        .drive_o(drive), .gate_o(gate), .sc_code_o(code), .line_start_o(strobe),
        .fast_loop_o(fast)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sync_strobe();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!strobe && n < 100);
    endtask

    // Starts at a falling edge with strobe high; stops at the next strobe.
    task automatic measure_line(output int period, output int drv, output int gpos, output int ngate);
        int n = 0;
        drv = 0; gpos = -1; ngate = 0;
        do begin
            if (n < 64) codes[n] = code;
            if (drive) drv++;
            if (gate) begin gpos = n; ngate++; end
            n++;
            @(negedge clk);
        end while (!strobe && n < 100);
        period = n;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 strobe in reset", int'(strobe), 0);
        chk("R11 drive in reset", int'(drive), 0);
        chk("R11 code in reset", int'(code), 0);
        chk("R11 gate in reset", int'(gate), 0);
        chk("R11 fast in reset", int'(fast), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 first strobe", int'(strobe), 1);
        chk("R10 fast while capturing", int'(fast), 1);
    endtask

    task automatic t_nominal();
        int p, d, g, ng;
        measure_line(p, d, g, ng);
        chk("R1 period", p, 32);
        chk("R2 drive width", d, 13);
        chk("R3 gate position", g, 1);
        chk("R3 gate count", ng, 1);
        for (int i = 0; i < 32; i++) begin
            int e;
            if (i == 3 || i == 4) e = 3;
            else if (i < 13) e = 2;
            else e = 0;
            chk($sformatf("R4 code at %0d", i), int'(codes[i]), e);
        end
    endtask

    task automatic t_advance();
        int p, d, g, ng;
        adv = 1'b1; @(negedge clk); adv = 1'b0;
        sync_strobe();
        measure_line(p, d, g, ng);
        chk("R5 advanced line", p, 31);
        chk("R8 drive on short line", d, 13);
        chk("R8 gate on short line", g, 1);
        measure_line(p, d, g, ng);
        chk("R5 line after advance", p, 32);
    endtask

    task automatic t_retard();
        int p, d, g, ng;
        ret = 1'b1; @(negedge clk); ret = 1'b0;
        sync_strobe();
        measure_line(p, d, g, ng);
        chk("R6 retarded line", p, 33);
        chk("R8 drive on long line", d, 13);
        chk("R8 gate on long line", g, 1);
        measure_line(p, d, g, ng);
        chk("R6 line after retard", p, 32);
    endtask

    task automatic t_double();
        int p, d, g, ng;
        adv = 1'b1; @(negedge clk); adv = 1'b0;
        repeat (3) @(negedge clk);
        ret = 1'b1; @(negedge clk); ret = 1'b0;
        sync_strobe();
        measure_line(p, d, g, ng);
        chk("R7 first request kept", p, 31);
        measure_line(p, d, g, ng);
        chk("R7 second request dropped", p, 32);
    endtask

    task automatic t_both();
        int p, d, g, ng;
        adv = 1'b1; ret = 1'b1; @(negedge clk); adv = 1'b0; ret = 1'b0;
        sync_strobe();
        measure_line(p, d, g, ng);
        chk("R7 both high ignored", p, 32);
    endtask

    task automatic t_blank();
        int p, d, g, ng;
        blank = 1'b1;
        measure_line(p, d, g, ng);
        for (int i = 1; i < 32; i++) begin
            int e;
            if (i == 3 || i == 4) e = 3;
            else if (i < 13) e = 2;
            else e = 1;
            chk($sformatf("R4 blank code at %0d", i), int'(codes[i]), e);
        end
        repeat (20) @(negedge clk);
        chk("R12 blank level held", int'(code), 1);
        blank = 1'b0;
        @(negedge clk);
        chk("R12 blank released after one clock", int'(code), 0);
        sync_strobe();
    endtask

    task automatic t_fast();
        repeat (10) sync_strobe();
        chk("R10 fast drops after capture", int'(fast), 0);
        vcr = 1'b1;
        @(negedge clk);
        chk("R9 fast in VCR mode", int'(fast), 1);
        repeat (40) @(negedge clk);
        chk("R9 fast held in VCR mode", int'(fast), 1);
        vcr = 1'b0;
        @(negedge clk);
        chk("R10 fast follows mode after capture", int'(fast), 0);
        sync_strobe();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_nominal();
                t_advance();
                t_retard();
                t_double();
                t_both();
                t_blank();
                t_fast();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule